// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block takes a serial audio stream made of a bit clock, a frame-sync or word-select line and a data line. It turns that stream into parallel 16-bit samples. All three serial inputs are oversampled in the system clock domain. A selectable edge of the bit clock marks each data bit. The receiver tracks where it is inside each channel slot and delivers one left/right pair, or one mono word, together with a single-cycle valid strobe.

An 8-bit format register selects the framing:
- delayed framing, with the MSB one bit after the word-select change;
- MSB-aligned framing, with the MSB on the first bit;
- LSB-aligned framing, with the LSB on the last bit before the next word-select change;
- a pulse-sync mono mode, in which a frame-sync pulse starts a 16-bit word.

The same register sets the bit clock edge, the frame-sync polarity, whether the sample is taken from the head or the tail of each slot, and whether slots are exactly 16 bits or longer. A write with the interface-clear bit set keeps the receiver quiet and discards any partial sample until a later write clears the bit.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, pcm_valid, pcm_mono, pcm_left and pcm_right are all 0 and the format register holds 00h. With 00h the receiver runs stereo, zero-delay, 16-bit slots, and word-select low marks the left slot.
- R2: The format register bits, from bit 7 down to bit 0, are: interface clear, test enable (no effect), head placement, long slot, bit-clock invert, frame-sync invert, pulse mode and delayed framing. A write on cfg_we loads all eight bits.
- R3: The effective frame level is frm_i XOR bit 2. In stereo modes an effective level of 0 marks the left slot and 1 marks the right slot. Each change of level at a sampling edge starts a new slot.
- R4: With head placement and delayed framing (for example 31h), the sample is the 16 bits sampled at slot positions 1 to 16. Position 0 is the first sampling edge of the slot.
- R5: With head placement and no delay (for example 34h), the sample is the bits at positions 0 to 15 of the slot. Later bits in a longer slot are ignored.
- R6: With tail placement and long slots (for example 14h), the sample is the last 16 bits before the level change that ends the slot, for any slot length from 16 to 32 bits.
- R7: With tail placement and bit 4 clear (for example 04h), each slot is taken as exactly 16 bits. The sample is positions 0 to 15, and no later bit changes it.
- R8: Data and frame-sync are sampled on the rising bit-clock edge when bit 3 is 0, and on the falling edge when bit 3 is 1.
- R9: A stereo pair is emitted when a right sample completes after a left sample. The left sample comes out on pcm_left, the right on pcm_right, pcm_mono is 0, and pcm_valid is high for exactly one cycle.
- R10: In pulse mode (for example 32h), a rising effective frame level starts a word whose MSB is the bit sampled at that edge. After 16 bits the word appears on both pcm_left and pcm_right, with pcm_mono at 1 and one valid pulse.
- R11: A right sample that completes with no left sample captured since the last pair, or since the last clear, produces no output.
- R12: While bit 7 is set, no output is produced, and the receiver state is discarded.
- R13: After a clear, nothing is captured until the first change of frame level. A slot already in progress at that time is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Format register write enable |
| cfg_wdata | input | 8 | Format register write data |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| frm_i | input | 1 | Word-select or frame-sync (asynchronous) |
| sdat_i | input | 1 | Serial data, MSB first (asynchronous) |
| pcm_left | output | SAMPLE_W | Left sample, or the mono word |
| pcm_right | output | SAMPLE_W | Right sample, or the mono word |
| pcm_valid | output | 1 | One-cycle strobe for a new output |
| pcm_mono | output | 1 | Output came from pulse mode |

## Verification
The bench builds the receiver with its default parameters: 16-bit samples, a slot counter that saturates at 32 bits, and two synchronizer stages. With these values, slots of 16, 20, 24 and 32 bits can be driven. That range shows the difference between head and tail placement, the one-bit delay in a 32-bit slot, and the short-slot mode cutting off a longer slot. The bit clock runs at one eighth of the system clock, so every serial edge crosses the full synchronizer. Driving the bit clock with either idle level covers both sampling edges.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  // Format register layout, MSB first.
  typedef struct packed {
    logic iface_clr;   // bit 7: hold receiver cleared
    logic test_en;     // bit 6: stored, no function
    logic head_place;  // bit 5: sample at head of slot
    logic long_frame;  // bit 4: slots longer than 16 bits
    logic clk_inv;     // bit 3: sample on falling bit-clock edge
    logic sync_inv;    // bit 2: invert frame line
    logic pulse_mode;  // bit 1: pulse-sync mono words
    logic delayed;     // bit 0: one-bit delay after slot start
  } fmt_t;

  localparam int SIG_SCLK = 0;
  localparam int SIG_FRM  = 1;
  localparam int SIG_DAT  = 2;
  localparam int SIG_CNT  = 3;

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] last
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign last = stg[STAGES];

endmodule

// File: rtl/sarx_stereo.sv
module sarx_stereo #(
  parameter int SAMPLE_W = 16,
  parameter int MAX_SLOT = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                evt,
  input  logic                frm_eff,
  input  logic                dat,
  input  logic                delayed,
  input  logic                head_place,
  input  logic                long_frame,
  output logic                cpl_o,
  output logic                cpl_right_o,
  output logic [SAMPLE_W-1:0] cpl_word_o
);
  localparam int CW = $clog2(MAX_SLOT + 1);
  localparam logic [CW-1:0] IDX_LAST  = CW'(SAMPLE_W - 1);
  localparam logic [CW-1:0] IDX_DLAST = CW'(SAMPLE_W);
  localparam logic [CW-1:0] CNT_MAX   = CW'(MAX_SLOT);

  logic                locked, prev, chan;
  logic [CW-1:0]       cnt;
  logic [SAMPLE_W-1:0] sh;

  logic                bnd, locked_now, chan_now, tail_mode, win_done, tail_done;
  logic [CW-1:0]       k_now, end_idx;
  logic [SAMPLE_W-1:0] sh_nx;

  always_comb begin
    bnd        = (frm_eff != prev);
    k_now      = bnd ? '0 : cnt;
    locked_now = locked | bnd;
    chan_now   = bnd ? frm_eff : chan;
    sh_nx      = {sh[SAMPLE_W-2:0], dat};
    tail_mode  = !head_place && long_frame;
    end_idx    = (head_place && delayed) ? IDX_DLAST : IDX_LAST;
    win_done   = !tail_mode && locked_now && (k_now == end_idx);
    tail_done  = tail_mode && locked && bnd && (cnt >= IDX_DLAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked      <= 1'b0;
      prev        <= 1'b0;
      chan        <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      cpl_o       <= 1'b0;
      cpl_right_o <= 1'b0;
      cpl_word_o  <= '0;
    end else begin
      cpl_o <= 1'b0;
      if (clr) begin
        locked <= 1'b0;
        cnt    <= '0;
        sh     <= '0;
        prev   <= frm_eff;
      end else if (evt) begin
        prev <= frm_eff;
        if (bnd) begin
          locked <= 1'b1;
          chan   <= frm_eff;
        end
        cnt <= (k_now != CNT_MAX) ? k_now + 1'b1 : k_now;
        sh  <= sh_nx;
        if (tail_done) begin
          cpl_o       <= 1'b1;
          cpl_right_o <= chan;
          cpl_word_o  <= sh;
        end else if (win_done) begin
          cpl_o       <= 1'b1;
          cpl_right_o <= chan_now;
          cpl_word_o  <= sh_nx;
        end
      end
    end
  end

  // R12: a clear silences the completion strobe.
  p_clr_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    clr |=> !cpl_o);

  // R13: no slot completes before the receiver has seen a slot start.
  p_cpl_locked_r13: assert property (@(posedge clk) disable iff (rst)
    cpl_o |-> locked);

endmodule

// File: rtl/sarx_pulse.sv
module sarx_pulse #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                evt,
  input  logic                sync_eff,
  input  logic                dat,
  output logic                cpl_o,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam int PCW = $clog2(SAMPLE_W);
  localparam logic [PCW-1:0] BIT_LAST = PCW'(SAMPLE_W - 1);

  logic                prev, active;
  logic [PCW-1:0]      cnt;
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] sh_nx;
  logic                start;

  always_comb begin
    start = sync_eff && !prev;
    sh_nx = {sh[SAMPLE_W-2:0], dat};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      cpl_o  <= 1'b0;
      word_o <= '0;
    end else begin
      cpl_o <= 1'b0;
      if (clr) begin
        active <= 1'b0;
        cnt    <= '0;
        sh     <= '0;
        prev   <= sync_eff;
      end else if (evt) begin
        prev <= sync_eff;
        if (start) begin
          active <= 1'b1;
          cnt    <= PCW'(1);
          sh     <= sh_nx;
        end else if (active) begin
          sh <= sh_nx;
          if (cnt == BIT_LAST) begin
            active <= 1'b0;
            cpl_o  <= 1'b1;
            word_o <= sh_nx;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R12: clearing silences pulse-mode completion.
  p_pclr_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    clr |=> !cpl_o);

  // R10: a finished word leaves the collector idle.
  p_word_ends_r10: assert property (@(posedge clk) disable iff (rst)
    cpl_o |-> !active);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W    = 16,
  parameter int MAX_SLOT    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_wdata,
  input  logic                sclk_i,
  input  logic                frm_i,
  input  logic                sdat_i,
  output logic [SAMPLE_W-1:0] pcm_left,
  output logic [SAMPLE_W-1:0] pcm_right,
  output logic                pcm_valid,
  output logic                pcm_mono
);
  import sarx_pkg::*;

  fmt_t cfg;

  always_ff @(posedge clk) begin
    if (rst)         cfg <= '0;
    else if (cfg_we) cfg <= fmt_t'(cfg_wdata);
  end

  logic [SIG_CNT-1:0] raw, s_lvl, s_last;

  always_comb begin
    raw           = '0;
    raw[SIG_SCLK] = sclk_i;
    raw[SIG_FRM]  = frm_i;
    raw[SIG_DAT]  = sdat_i;
  end

  sarx_sync #(.W(SIG_CNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .lvl (s_lvl),
    .last(s_last)
  );

  logic evt, frm_eff, st_clr, pu_clr;

  always_comb begin
    evt     = cfg.clk_inv ? (s_last[SIG_SCLK] && !s_lvl[SIG_SCLK])
                          : (!s_last[SIG_SCLK] && s_lvl[SIG_SCLK]);
    frm_eff = s_lvl[SIG_FRM] ^ cfg.sync_inv;
    st_clr  = cfg.iface_clr || cfg.pulse_mode;
    pu_clr  = cfg.iface_clr || !cfg.pulse_mode;
  end

  logic                st_cpl, st_right, pu_cpl;
  logic [SAMPLE_W-1:0] st_word, pu_word;

  sarx_stereo #(.SAMPLE_W(SAMPLE_W), .MAX_SLOT(MAX_SLOT)) i_stereo (
    .clk        (clk),
    .rst        (rst),
    .clr        (st_clr),
    .evt        (evt),
    .frm_eff    (frm_eff),
    .dat        (s_lvl[SIG_DAT]),
    .delayed    (cfg.delayed),
    .head_place (cfg.head_place),
    .long_frame (cfg.long_frame),
    .cpl_o      (st_cpl),
    .cpl_right_o(st_right),
    .cpl_word_o (st_word)
  );

  sarx_pulse #(.SAMPLE_W(SAMPLE_W)) i_pulse (
    .clk     (clk),
    .rst     (rst),
    .clr     (pu_clr),
    .evt     (evt),
    .sync_eff(frm_eff),
    .dat     (s_lvl[SIG_DAT]),
    .cpl_o   (pu_cpl),
    .word_o  (pu_word)
  );

  logic                have_left;
  logic [SAMPLE_W-1:0] left_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_left <= 1'b0;
      left_hold <= '0;
      pcm_left  <= '0;
      pcm_right <= '0;
      pcm_valid <= 1'b0;
      pcm_mono  <= 1'b0;
    end else begin
      pcm_valid <= 1'b0;
      if (cfg.iface_clr) begin
        have_left <= 1'b0;
      end else begin
        if (st_cpl) begin
          if (!st_right) begin
            left_hold <= st_word;
            have_left <= 1'b1;
          end else if (have_left) begin
            pcm_left  <= left_hold;
            pcm_right <= st_word;
            pcm_mono  <= 1'b0;
            pcm_valid <= 1'b1;
            have_left <= 1'b0;
          end
        end
        if (pu_cpl) begin
          pcm_left  <= pu_word;
          pcm_right <= pu_word;
          pcm_mono  <= 1'b1;
          pcm_valid <= 1'b1;
        end
      end
    end
  end

  // R9: the output strobe lasts one cycle.
  p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |=> !pcm_valid);

  // R10: a mono word appears on both outputs.
  p_mono_copy_r10: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid && pcm_mono) |-> (pcm_left == pcm_right));

  // R12: a held clear keeps the outputs silent.
  p_hold_silent_r12: assert property (@(posedge clk) disable iff (rst)
    (cfg.iface_clr && $past(cfg.iface_clr) && $past(cfg.iface_clr, 2)) |-> !pcm_valid);

  // R8: sampling edges are never back to back.
  p_edge_spaced_r8: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);

endmodule

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        bclk = 1'b0, lr = 1'b0, sd = 1'b0;
  logic [15:0] pcm_left, pcm_right;
  logic        pcm_valid, pcm_mono;

  always #2 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sclk_i(bclk), .frm_i(lr), .sdat_i(sd),
    .pcm_left(pcm_left), .pcm_right(pcm_right),
    .pcm_valid(pcm_valid), .pcm_mono(pcm_mono)
  );

  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    logic        mono;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_run = 0, n_fail = 0, n_valid = 0;
  string       cur_tag = "R1";
  logic [7:0]  cur_cfg = 8'h00;
  logic        sinv = 1'b0, finv = 1'b0;
  logic [31:0] seed = 32'h1D2C_3B4A;

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Sample expected from the slot bits, per R4..R7.
  function automatic logic [15:0] exp_word(input logic [31:0] b, input int len);
    int s;
    if (cur_cfg[5])      s = len - int'(cur_cfg[0]) - 16;
    else if (!cur_cfg[4]) s = len - 16;
    else                 s = 0;
    return 16'(b >> s);
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pcm_valid) begin
      n_valid++;
      if (q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL %s actual=%h/%h/%b expected=no output", cur_tag, pcm_left, pcm_right, pcm_mono);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, {7'd0, pcm_left, pcm_right, pcm_mono}, {7'd0, e.l, e.r, e.mono});
      end
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic wr(input logic [7:0] v);
    cyc(); cfg_we = 1'b1; cfg_wdata = v;
    cyc(); cfg_we = 1'b0;
  endtask

  task automatic sbit(input logic d, input logic e);
    bclk = sinv; sd = d; lr = e ^ finv;
    repeat (4) cyc();
    bclk = ~sinv;
    repeat (4) cyc();
  endtask

  task automatic start(input logic [7:0] v, input logic idle);
    wr(v | 8'h80);
    cur_cfg = v; sinv = v[3]; finv = v[2];
    bclk = sinv; lr = idle ^ finv; sd = 1'b0;
    repeat (10) cyc();
    wr(v);
    repeat (6) cyc();
    sbit(1'b0, idle); sbit(1'b0, idle);
  endtask

  task automatic slot(input logic [31:0] b, input int len, input logic e);
    for (int k = 0; k < len; k++) sbit(b[len-1-k], e);
  endtask

  task automatic pair(input int len, input bit push, input string tag);
    logic [31:0] lb, rb;
    exp_t e;
    lb = nxt(); rb = nxt();
    if (push) begin
      e.l = exp_word(lb, len); e.r = exp_word(rb, len); e.mono = 1'b0; e.tag = tag;
      q.push_back(e);
    end
    slot(lb, len, 1'b0);
    slot(rb, len, 1'b1);
  endtask

  task automatic finish_phase(input string tag);
    sbit(1'b0, 1'b0);
    repeat (40) cyc();
    chk({tag, " pending"}, 40'(q.size()), 40'd0);
    q.delete();
  endtask

  task automatic mono_word(input string tag);
    logic [15:0] w;
    exp_t e;
    w = 16'(nxt());
    e.l = w; e.r = w; e.mono = 1'b1; e.tag = tag;
    q.push_back(e);
    for (int k = 0; k < 16; k++) sbit(w[15-k], k == 0);
    for (int k = 0; k < 3; k++) sbit(1'b0, 1'b0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v0;
    repeat (4) cyc();
    rst = 1'b0;
    cyc();
    // R1: reset state
    chk("R1 valid", 40'(pcm_valid), 40'd0);
    chk("R1 mono",  40'(pcm_mono),  40'd0);
    chk("R1 left",  40'(pcm_left),  40'd0);
    chk("R1 right", 40'(pcm_right), 40'd0);

    // R1/R2: default register 00h, 16-bit slots, low = left
    cur_tag = "R1"; lr = 1'b1; repeat (6) cyc();
    sbit(1'b0, 1'b1); sbit(1'b0, 1'b1);
    pair(16, 1, "R1 default"); pair(16, 1, "R1 default");
    finish_phase("R1");

    // R4/R3: delayed head placement, low = left, 32-bit slots
    cur_tag = "R4"; start(8'h31, 1'b1);
    pair(32, 1, "R4 delayed"); pair(32, 1, "R4 delayed");
    finish_phase("R4");

    // R5/R3: zero-delay head placement, inverted frame, 24-bit slots
    cur_tag = "R5"; start(8'h34, 1'b1);
    pair(24, 1, "R5 head"); pair(16, 1, "R5 head"); pair(32, 1, "R5 head");
    finish_phase("R5");

    // R6: tail placement with long slots
    cur_tag = "R6"; start(8'h14, 1'b1);
    pair(24, 1, "R6 tail"); pair(20, 1, "R6 tail"); pair(16, 1, "R6 tail");
    finish_phase("R6");

    // R7: exact 16-bit slots, then a longer slot cut at 16
    cur_tag = "R7"; start(8'h04, 1'b1);
    pair(16, 1, "R7 short"); pair(16, 1, "R7 short"); pair(24, 1, "R7 cut");
    finish_phase("R7");

    // R8: falling-edge sampling
    cur_tag = "R8"; start(8'h3C, 1'b1);
    pair(24, 1, "R8 falling"); pair(16, 1, "R8 falling");
    finish_phase("R8");
    cur_tag = "R8"; start(8'h1C, 1'b1);
    pair(20, 1, "R8 falling tail");
    finish_phase("R8");

    // R10: pulse-sync mono words, both polarities
    cur_tag = "R10"; start(8'h32, 1'b0);
    mono_word("R10 mono"); mono_word("R10 mono"); mono_word("R10 mono");
    finish_phase("R10");
    cur_tag = "R10"; start(8'h36, 1'b0);
    mono_word("R10 inverted sync"); mono_word("R10 inverted sync");
    finish_phase("R10");

    // R11: lone right slot produces nothing, then a normal pair
    cur_tag = "R11"; start(8'h34, 1'b0);
    slot(nxt(), 16, 1'b1);
    pair(16, 1, "R11 after lone right");
    finish_phase("R11");

    // R13: slot in progress at release is ignored
    cur_tag = "R13"; start(8'h34, 1'b0);
    slot(nxt(), 16, 1'b0);
    slot(nxt(), 16, 1'b1);
    pair(16, 1, "R13 after unlocked slot");
    finish_phase("R13");

    // R12: held clear discards everything
    cur_tag = "R12"; start(8'h34, 1'b1);
    wr(8'hB4);
    v0 = n_valid;
    pair(16, 0, "R12"); pair(24, 0, "R12");
    sbit(1'b0, 1'b0);
    repeat (40) cyc();
    chk("R12 valids during hold", 40'(n_valid - v0), 40'd0);
    finish_phase("R12");
    cur_tag = "R12"; start(8'h34, 1'b1);
    pair(16, 1, "R12 recovery");
    finish_phase("R12");

    // R9: back-to-back pairs each give one output
    cur_tag = "R9"; start(8'h04, 1'b1);
    v0 = n_valid;
    pair(16, 1, "R9"); pair(16, 1, "R9"); pair(16, 1, "R9");
    finish_phase("R9");
    chk("R9 pair count", 40'(n_valid - v0), 40'd3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule